// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Key

This block is a 32-bit down-counting watchdog behind an APB slave port. A clock-enable input paces the count. The first time the count runs out, the block raises a raw interrupt and keeps counting from the reload value. If the count runs out a second time while that interrupt has not been cleared, the block latches a reset request and stops counting. Software services the watchdog by writing the clear register, which drops the interrupt and restarts the count from the reload value.

A key register guards every other register against stray writes. A test mode lets software drive both outputs directly from a register. Read-only identification words sit at the top of the 4 KB window. A parameter selects a reduced variant. That variant has no test-mode registers and it freezes the control register once the interrupt enable has been set.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, control, raw interrupt, reset status, key lock, test-mode enable and test outputs are all 0, the reload value (0x000) and the count (0x004) both read 0xFFFFFFFF, the counter is running, and both outputs are low.
- R2: Control (0x008) keeps only bit 0 (interrupt enable) and bit 1 (reset enable). All other written bits are dropped and read back as 0.
- R3: A write to the reload register (0x000) stores the value, loads it into the count on the same edge (ahead of any tick in that cycle) and sets the counter running.
- R4: Each cycle with tick_en high and the counter running, the count drops by one. A tick that takes the count from 1 to 0 is an expiry, and a tick at a count of 0 reloads it. An expiry with the raw interrupt clear sets the raw interrupt. An expiry with the raw interrupt already set sets the reset status and stops the counter.
- R5: Any write to the clear register (0x00C) clears the raw interrupt and reloads the count from the reload value. It takes priority over a tick in the same cycle, so no expiry occurs on that edge.
- R6: Writing 0x1ACCE551 to the key register (0xC00) unlocks the block, and writing any other value locks it. The key register reads 1 when locked. While locked, writes to every other register have no effect.
- R7: irq_o equals raw interrupt AND interrupt enable. The raw status (0x010) reads the raw interrupt in bit 0, and the masked status (0x014) reads irq_o in bit 0.
- R8: rst_req_o equals reset status AND reset enable. The reset status stays set until block reset, even across a clear-register write.
- R9: When test-mode bit 0 (0xF00) is set, irq_o follows bit 1 and rst_req_o follows bit 0 of the test-output register (0xF04), bypassing the status logic. Test mode reads back bit 0.
- R10: With ALT_VARIANT=1, control writes have no effect once the interrupt enable is set. In that variant 0xF00 and 0xF04 are unmapped: writes do nothing and reads return 0.
- R11: Reads of the clear register, the test-output register and unmapped offsets return 0. Writes to the count, raw status, masked status and identification offsets have no effect.
- R12: Identification word i (i = 0..11) at 0xFD0+4*i reads, in its low byte, 04 00 00 00 24 B8 1B 00 0D F0 05 B1 (default variant) or 00 00 00 00 05 18 18 01 0D F0 05 B1 (ALT_VARIANT=1). pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| irq_o | output | 1 | Interrupt output |
| rst_req_o | output | 1 | Reset request output |

## Verification
A wrong count shows at the count register on the next read and shifts the expiry edge, so irq_o rises one or more cycles away from where the reference expects it. A bad raw-interrupt or reset-status bit shows on irq_o or rst_req_o in the first cycle its enable is set. A lock bit that is wrong leaks or drops a write, which shows on the next read of the target register. The bench compares both outputs on every cycle, and compares read data on every read cycle. Wrong state therefore shows within one cycle of reaching an enabled output or a read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_W = 32;
  localparam int OFF_W = 12;

  localparam logic [OFF_W-1:0] A_RELOAD = 12'h000;
  localparam logic [OFF_W-1:0] A_COUNT  = 12'h004;
  localparam logic [OFF_W-1:0] A_CTRL   = 12'h008;
  localparam logic [OFF_W-1:0] A_ICLR   = 12'h00C;
  localparam logic [OFF_W-1:0] A_RAW    = 12'h010;
  localparam logic [OFF_W-1:0] A_MASKED = 12'h014;
  localparam logic [OFF_W-1:0] A_KEY    = 12'hC00;
  localparam logic [OFF_W-1:0] A_TMODE  = 12'hF00;
  localparam logic [OFF_W-1:0] A_TOUT   = 12'hF04;
  localparam logic [OFF_W-1:0] A_ID_LO  = 12'hFD0;
  localparam logic [OFF_W-1:0] A_ID_HI  = 12'hFFC;

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_en;
    logic irq_en;
  } ctrl_t;

  // identification byte for word index idx; upper words shared by both variants
  function automatic logic [7:0] id_byte(input int idx, input bit alt);
    logic [7:0] b;
    case (idx)
      0:  b = alt ? 8'h00 : 8'h04;
      4:  b = alt ? 8'h05 : 8'h24;
      5:  b = alt ? 8'h18 : 8'hB8;
      6:  b = alt ? 8'h18 : 8'h1B;
      7:  b = alt ? 8'h01 : 8'h00;
      8:  b = 8'h0D;
      9:  b = 8'hF0;
      10: b = 8'h05;
      11: b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             stop,
  output logic [CNT_W-1:0] count_q,
  output logic             running_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_d;
  logic             running_d;
  logic             step_en;

  // a bus reload in the same cycle wins over the tick
  assign step_en = tick && running_q && !load_we && !reload_req;
  assign expire  = step_en && (count_q == ONE);

  always_comb begin
    count_d   = count_q;
    running_d = running_q;
    if (load_we) begin
      count_d   = load_val;
      running_d = 1'b1;
    end else if (reload_req) begin
      count_d = reload_val;
    end else if (step_en) begin
      if (count_q == '0) count_d = reload_val;
      else               count_d = count_q - ONE;
    end
    if (stop) running_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= RESET_LOAD;
      running_q <= 1'b1;
    end else begin
      count_q   <= count_d;
      running_q <= running_d;
    end
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       iclr_we,
  input  ctrl_t      ctrl,
  input  logic       itcr,
  input  logic [1:0] itop,
  output logic       raw_q,
  output logic       rstat_q,
  output logic       stop,
  output logic       irq_o,
  output logic       rst_o
);
  logic raw_d;
  logic rstat_d;

  assign stop = expire && raw_q;

  always_comb begin
    raw_d   = raw_q;
    rstat_d = rstat_q;
    if (iclr_we)            raw_d   = 1'b0;
    else if (expire)        raw_d   = 1'b1;
    if (stop)               rstat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= 1'b0;
      rstat_q <= 1'b0;
    end else begin
      raw_q   <= raw_d;
      rstat_q <= rstat_d;
    end
  end

  always_comb begin
    if (itcr) begin
      irq_o = itop[1];
      rst_o = itop[0];
    end else begin
      irq_o = raw_q && ctrl.irq_en;
      rst_o = rstat_q && ctrl.rst_en;
    end
  end
endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter bit ALT_VARIANT = 1'b0,
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [OFF_W-1:0] paddr,
  input  logic [BUS_W-1:0] pwdata,
  input  logic [CNT_W-1:0] count_q,
  input  logic             raw_q,
  output logic [BUS_W-1:0] prdata,
  output logic [CNT_W-1:0] load_q,
  output ctrl_t            ctrl_q,
  output logic             lock_q,
  output logic             itcr_q,
  output logic [1:0]       itop_q,
  output logic             load_we,
  output logic             iclr_we
);
  logic             bus_wr;
  logic             wr_ok;
  logic [CNT_W-1:0] load_d;
  ctrl_t            ctrl_d;
  logic             lock_d;
  logic             ctrl_frozen;
  logic [OFF_W-1:0] id_off;

  assign bus_wr  = psel && penable && pwrite;
  assign wr_ok   = bus_wr && (!lock_q || paddr == A_KEY);
  assign load_we = wr_ok && paddr == A_RELOAD;
  assign iclr_we = wr_ok && paddr == A_ICLR;
  assign ctrl_frozen = ALT_VARIANT && ctrl_q.irq_en;

  always_comb begin
    load_d = load_q;
    ctrl_d = ctrl_q;
    lock_d = lock_q;
    if (load_we) load_d = pwdata[CNT_W-1:0];
    if (wr_ok && paddr == A_CTRL && !ctrl_frozen) ctrl_d = ctrl_t'(pwdata[1:0]);
    if (wr_ok && paddr == A_KEY) lock_d = (pwdata != UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= RESET_LOAD;
      ctrl_q <= '0;
      lock_q <= 1'b0;
    end else begin
      load_q <= load_d;
      ctrl_q <= ctrl_d;
      lock_q <= lock_d;
    end
  end

  generate
    if (ALT_VARIANT) begin : g_no_test
      assign itcr_q = 1'b0;
      assign itop_q = 2'b00;
    end else begin : g_test
      logic       itcr_d;
      logic [1:0] itop_d;
      always_comb begin
        itcr_d = itcr_q;
        itop_d = itop_q;
        if (wr_ok && paddr == A_TMODE) itcr_d = pwdata[0];
        if (wr_ok && paddr == A_TOUT)  itop_d = pwdata[1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          itcr_q <= 1'b0;
          itop_q <= 2'b00;
        end else begin
          itcr_q <= itcr_d;
          itop_q <= itop_d;
        end
      end
    end
  endgenerate

  assign id_off = paddr - A_ID_LO;

  always_comb begin
    prdata = '0;
    case (paddr)
      A_RELOAD: prdata[CNT_W-1:0] = load_q;
      A_COUNT:  prdata[CNT_W-1:0] = count_q;
      A_CTRL:   prdata[1:0]       = ctrl_q;
      A_RAW:    prdata[0]         = raw_q;
      A_MASKED: prdata[0]         = raw_q && ctrl_q.irq_en;
      A_KEY:    prdata[0]         = lock_q;
      A_TMODE:  prdata[0]         = itcr_q;
      default: begin
        if (paddr >= A_ID_LO && paddr <= A_ID_HI && paddr[1:0] == 2'b00)
          prdata[7:0] = id_byte(int'(id_off[OFF_W-1:2]), ALT_VARIANT);
      end
    endcase
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter bit ALT_VARIANT = 1'b0,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tick_en,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_n;
  logic [CNT_W-1:0]       count_q;
  logic [CNT_W-1:0]       load_q;
  logic                   running_q;
  logic                   expire;
  logic                   stop;
  logic                   raw_q;
  logic                   rstat_q;
  ctrl_t                  ctrl_q;
  logic                   lock_q;
  logic                   itcr_q;
  logic [1:0]             itop_q;
  logic                   load_we;
  logic                   iclr_we;

  // reset asserts at once, releases after SYNC_STAGES edges
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = sync_q[SYNC_STAGES-1];

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  wdog_regfile #(
    .ALT_VARIANT(ALT_VARIANT), .CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)
  ) u_regs (
    .clk(pclk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .count_q(count_q), .raw_q(raw_q),
    .prdata(prdata), .load_q(load_q), .ctrl_q(ctrl_q), .lock_q(lock_q),
    .itcr_q(itcr_q), .itop_q(itop_q), .load_we(load_we), .iclr_we(iclr_we)
  );

  wdog_counter #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)) u_cnt (
    .clk(pclk), .rst_n(rst_n), .tick(tick_en), .load_we(load_we),
    .load_val(pwdata[CNT_W-1:0]), .reload_req(iclr_we), .reload_val(load_q),
    .stop(stop), .count_q(count_q), .running_q(running_q), .expire(expire)
  );

  wdog_status u_stat (
    .clk(pclk), .rst_n(rst_n), .expire(expire), .iclr_we(iclr_we),
    .ctrl(ctrl_q), .itcr(itcr_q), .itop(itop_q), .raw_q(raw_q),
    .rstat_q(rstat_q), .stop(stop), .irq_o(irq_o), .rst_o(rst_req_o)
  );
endmodule

// File: rtl/wdog_sva.sv
module wdog_sva
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [11:0]      paddr,
  input logic [31:0]      pwdata,
  input logic [31:0]      prdata,
  input logic             irq_o,
  input logic             lock_q,
  input logic [31:0]      load_q,
  input logic [31:0]      count_q,
  input logic             running_q,
  input logic             raw_q,
  input logic             rstat_q,
  input logic             itcr_q,
  input logic [1:0]       ctrl_q
);
  logic wr;
  assign wr = psel && penable && pwrite;

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !lock_q && paddr == A_RELOAD) |=> (count_q == $past(pwdata) && running_q)); // R3
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && lock_q && paddr == A_RELOAD) |=> $stable(load_q)); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !lock_q && paddr == A_ICLR) |=> (!raw_q && count_q == $past(load_q))); // R5
  AST_STOP_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstat_q) |-> !running_q); // R4
  AST_RSTAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rstat_q |=> rstat_q); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!itcr_q && !ctrl_q[0]) |-> !irq_o); // R7
  AST_CTRL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == A_CTRL) |-> prdata[31:2] == '0); // R2
endmodule

bind twostage_wdog wdog_sva u_sva (
  .clk(pclk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o),
  .lock_q(lock_q), .load_q(load_q), .count_q(count_q), .running_q(running_q),
  .raw_q(raw_q), .rstat_q(rstat_q), .itcr_q(itcr_q), .ctrl_q(ctrl_q)
);

// File: tb/twostage_wdog_test.sv
module twostage_wdog_test;
  logic        clk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite, tick_en;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr, irq, rstq;
  logic        a_psel, a_penable, a_pwrite;
  logic [11:0] a_paddr;
  logic [31:0] a_pwdata, a_prdata;
  logic        a_pready, a_pslverr, a_irq, a_rstq;

  int total = 0;
  int bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  twostage_wdog uut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tick_en(tick_en), .irq_o(irq), .rst_req_o(rstq)
  );

  twostage_wdog #(.ALT_VARIANT(1'b1)) uut_alt (
    .pclk(clk), .presetn(presetn), .psel(a_psel), .penable(a_penable), .pwrite(a_pwrite),
    .paddr(a_paddr), .pwdata(a_pwdata), .prdata(a_prdata), .pready(a_pready),
    .pslverr(a_pslverr), .tick_en(1'b0), .irq_o(a_irq), .rst_req_o(a_rstq)
  );

  // behavioural reference for the default variant
  logic [31:0] m_load, m_count;
  logic [1:0]  m_ctrl, m_itop;
  bit          m_run, m_lock, m_itcr, m_raw, m_rstat;
  int          sync_cnt;

  function automatic logic [7:0] exp_id(int i, bit alt);
    logic [7:0] dflt [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h24, 8'hB8, 8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [7:0] altv [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h18, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return alt ? altv[i] : dflt[i];
  endfunction

  function automatic logic [31:0] mread(logic [11:0] a);
    if (a == 12'h000) return m_load;
    if (a == 12'h004) return m_count;
    if (a == 12'h008) return {30'd0, m_ctrl};
    if (a == 12'h010) return {31'd0, m_raw};
    if (a == 12'h014) return {31'd0, m_raw & m_ctrl[0]};
    if (a == 12'hC00) return {31'd0, m_lock};
    if (a == 12'hF00) return {31'd0, m_itcr};
    if (a >= 12'hFD0 && a[1:0] == 2'b00) return {24'd0, exp_id(int'((a - 12'hFD0) >> 2), 1'b0)};
    return 32'd0;
  endfunction

  function automatic bit m_irq();
    return m_itcr ? m_itop[1] : (m_raw & m_ctrl[0]);
  endfunction
  function automatic bit m_rst();
    return m_itcr ? m_itop[0] : (m_rstat & m_ctrl[1]);
  endfunction

  always @(posedge clk or negedge presetn) begin
    if (!presetn) begin
      m_load = 32'hFFFF_FFFF; m_count = 32'hFFFF_FFFF; m_run = 1;
      m_ctrl = 0; m_itop = 0; m_lock = 0; m_itcr = 0; m_raw = 0; m_rstat = 0;
      sync_cnt = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else begin
      bit reloaded;
      reloaded = 0;
      if (psel && penable && pwrite && (!m_lock || paddr == 12'hC00)) begin
        case (paddr)
          12'h000: begin m_load = pwdata; m_count = pwdata; m_run = 1; reloaded = 1; end
          12'h008: m_ctrl = pwdata[1:0];
          12'h00C: begin m_raw = 0; m_count = m_load; reloaded = 1; end
          12'hC00: m_lock = (pwdata != 32'h1ACCE551);
          12'hF00: m_itcr = pwdata[0];
          12'hF04: m_itop = pwdata[1:0];
          default: ;
        endcase
      end
      if (!reloaded && tick_en && m_run) begin
        if (m_count == 0) m_count = m_load;
        else begin
          m_count = m_count - 1;
          if (m_count == 0) begin
            if (m_raw) begin m_rstat = 1; m_run = 0; end
            else m_raw = 1;
          end
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R7 irq_o vs model", {31'd0, irq}, {31'd0, m_irq()});
      chk("R8 rst_req_o vs model", {31'd0, rstq}, {31'd0, m_rst()});
      chk("R12 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
      if (psel && !pwrite) chk("R11 prdata vs model", prdata, mread(paddr));
    end
  end

  task automatic bus_wr(bit alt, logic [11:0] a, logic [31:0] d, bit tick_acc = 0);
    @(posedge clk); #1;
    if (alt) begin a_psel = 1; a_pwrite = 1; a_paddr = a; a_pwdata = d; end
    else begin psel = 1; pwrite = 1; paddr = a; pwdata = d; end
    @(posedge clk); #1;
    if (alt) a_penable = 1; else penable = 1;
    tick_en = tick_acc;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0; a_psel = 0; a_penable = 0; a_pwrite = 0;
    tick_en = 0;
  endtask

  task automatic bus_rd(bit alt, logic [11:0] a, output logic [31:0] d, output logic [31:0] e);
    @(posedge clk); #1;
    if (alt) begin a_psel = 1; a_pwrite = 0; a_paddr = a; end
    else begin psel = 1; pwrite = 0; paddr = a; end
    @(posedge clk); #1;
    if (alt) a_penable = 1; else penable = 1;
    @(negedge clk);
    d = alt ? a_prdata : prdata;
    e = mread(a);
    @(posedge clk); #1;
    psel = 0; penable = 0; a_psel = 0; a_penable = 0;
  endtask

  task automatic rd_model(logic [11:0] a, string tag);
    logic [31:0] d, e;
    bus_rd(0, a, d, e);
    chk(tag, d, e);
  endtask

  task automatic rd_lit(bit alt, logic [11:0] a, logic [31:0] exp, string tag);
    logic [31:0] d, e;
    bus_rd(alt, a, d, e);
    chk(tag, d, exp);
  endtask

  task automatic ticks(int n);
    @(posedge clk); #1;
    tick_en = 1;
    repeat (n) @(posedge clk);
    #1 tick_en = 0;
  endtask

  task automatic do_reset();
    cmp_on = 0;
    presetn = 0;
    repeat (2) @(posedge clk);
    #1 presetn = 1;
    repeat (4) @(posedge clk);
    #1 cmp_on = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: all requirements, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    presetn = 1; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; tick_en = 0;
    a_psel = 0; a_penable = 0; a_pwrite = 0; a_paddr = 0; a_pwdata = 0;
    #3;
    do_reset();

    // R1 reset state
    rd_lit(0, 12'h000, 32'hFFFF_FFFF, "R1 reload after reset");
    rd_lit(0, 12'h004, 32'hFFFF_FFFF, "R1 count after reset");
    rd_lit(0, 12'h008, 32'd0, "R1 control after reset");
    rd_lit(0, 12'h010, 32'd0, "R1 raw after reset");
    rd_lit(0, 12'hC00, 32'd0, "R1 lock after reset");
    rd_lit(0, 12'hF00, 32'd0, "R1 test mode after reset");
    chk("R1 outputs low", {30'd0, irq, rstq}, 32'd0);
    ticks(3);
    rd_lit(0, 12'h004, 32'hFFFF_FFFC, "R1 counter running");

    // R2 control masking
    bus_wr(0, 12'h008, 32'hFFFF_FFFF);
    rd_lit(0, 12'h008, 32'd3, "R2 control keeps two bits");
    bus_wr(0, 12'h008, 32'h0000_0001);

    // R3 reload write, R4 two-stage expiry
    bus_wr(0, 12'h000, 32'd5);
    rd_lit(0, 12'h004, 32'd5, "R3 count loaded");
    ticks(4);
    chk("R4 no irq before expiry", {31'd0, irq}, 32'd0);
    ticks(1);
    rd_lit(0, 12'h010, 32'd1, "R4 first expiry sets raw");
    rd_lit(0, 12'h014, 32'd1, "R7 masked status");
    chk("R7 irq after expiry", {31'd0, irq}, 32'd1);
    ticks(1);
    rd_lit(0, 12'h004, 32'd5, "R4 reload at zero");
    ticks(5);
    chk("R8 reset masked by enable", {31'd0, rstq}, 32'd0);
    ticks(3);
    rd_lit(0, 12'h004, 32'd0, "R4 counter stopped");
    bus_wr(0, 12'h008, 32'd3);
    chk("R8 reset request enabled", {31'd0, rstq}, 32'd1);
    bus_wr(0, 12'h00C, 32'd0);
    rd_lit(0, 12'h010, 32'd0, "R5 clear drops raw");
    chk("R8 reset status sticky", {31'd0, rstq}, 32'd1);
    ticks(2);
    rd_lit(0, 12'h004, 32'd5, "R4 stays stopped after clear");

    // R5 clear beats tick; R3 load beats tick
    do_reset();
    bus_wr(0, 12'h008, 32'd1);
    bus_wr(0, 12'h000, 32'd3);
    ticks(2);
    bus_wr(0, 12'h00C, 32'd0, 1);
    rd_lit(0, 12'h010, 32'd0, "R5 no expiry on clear edge");
    rd_lit(0, 12'h004, 32'd3, "R5 count reloaded");
    ticks(3);
    rd_lit(0, 12'h010, 32'd1, "R4 expiry after clear");
    bus_wr(0, 12'h000, 32'd9, 1);
    rd_lit(0, 12'h004, 32'd9, "R3 load wins over tick");

    // R6 key lock
    bus_wr(0, 12'hC00, 32'd0);
    rd_lit(0, 12'hC00, 32'd1, "R6 locked reads 1");
    bus_wr(0, 12'h000, 32'd7);
    rd_lit(0, 12'h000, 32'd9, "R6 locked reload write ignored");
    bus_wr(0, 12'h008, 32'd0);
    rd_lit(0, 12'h008, 32'd1, "R6 locked control write ignored");
    bus_wr(0, 12'hC00, 32'h1ACC_E551);
    rd_lit(0, 12'hC00, 32'd0, "R6 key unlocks");
    bus_wr(0, 12'h000, 32'd7);
    rd_lit(0, 12'h000, 32'd7, "R6 write after unlock");

    // R9 test override
    bus_wr(0, 12'h008, 32'd0);
    bus_wr(0, 12'hF04, 32'd2);
    bus_wr(0, 12'hF00, 32'd1);
    chk("R9 irq from test bit 1", {30'd0, irq, rstq}, 32'd2);
    bus_wr(0, 12'hF04, 32'd1);
    chk("R9 reset from test bit 0", {30'd0, irq, rstq}, 32'd1);
    rd_lit(0, 12'hF00, 32'd1, "R9 test mode reads back");
    rd_lit(0, 12'hF04, 32'd0, "R11 test outputs read 0");
    bus_wr(0, 12'hF00, 32'd0);

    // R11 reads of write-only/unmapped, writes to read-only
    rd_lit(0, 12'h00C, 32'd0, "R11 clear reads 0");
    rd_lit(0, 12'h100, 32'd0, "R11 unmapped reads 0");
    bus_wr(0, 12'h004, 32'h55);
    rd_lit(0, 12'h004, 32'd7, "R11 count write ignored");
    bus_wr(0, 12'h010, 32'd0);
    rd_lit(0, 12'h010, 32'd1, "R11 raw write ignored");
    bus_wr(0, 12'hFE0, 32'hFF);
    rd_lit(0, 12'hFE0, 32'h24, "R11 id write ignored");

    // R12 identification words
    for (int i = 0; i < 12; i++) begin
      rd_model(12'(12'hFD0 + 4 * i), "R12 id word vs model");
    end
    rd_lit(0, 12'hFF0, 32'h0D, "R12 id word 8");

    // R10 reduced variant
    bus_wr(1, 12'h008, 32'd2);
    rd_lit(1, 12'h008, 32'd2, "R10 control writable before enable");
    bus_wr(1, 12'h008, 32'd1);
    bus_wr(1, 12'h008, 32'd0);
    rd_lit(1, 12'h008, 32'd1, "R10 control frozen");
    bus_wr(1, 12'hF00, 32'd1);
    rd_lit(1, 12'hF00, 32'd0, "R10 test mode absent");
    bus_wr(1, 12'hF04, 32'd3);
    chk("R10 test outputs no effect", {30'd0, a_irq, a_rstq}, 32'd0);
    rd_lit(1, 12'hFE0, 32'h05, "R10 id word 4 variant");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule